// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Bus Front End

This block is the digital front end of a four-channel 12-bit voltage-output converter. A microprocessor bus writes a code into one of four input registers, and a 2-bit address chooses the register. The bus may be 12 bits wide, or only 8 bits wide. In the narrow case a code is written in two parts: first the upper 8 bits, then the low nibble. On the second write the nibble is taken from the top four bus lines.

A global transfer copies all four input registers into four output registers on one clock edge, so every channel changes at the same moment. On the way into an output register, the top three code bits are recoded into a 7-bit thermometer of equally weighted segments. The nine lower bits pass through unchanged.

A clear command or the asynchronous power-on reset forces every output register to the mid-scale code. Codes are offset binary: 0x800 is zero, 0x000 is negative full scale and 0xFFF is full scale minus one LSB.

Top module: `quad_dac_front`

## Requirements
- R1: After reset (`rst_n` low), every input register holds 0x800. Every output word reads 0x1E00, which is thermometer 0001111 followed by nine zero bits.
- R2: A write with `wide` high loads all 12 bits of `bus_d` into the input register chosen by `addr` (0 to 3). It leaves the other three input registers unchanged.
- R3: A write occurs only on a clock edge where `cs` and `wr1` are both high. With either one low, no input register changes.
- R4: A write with `wide` low changes only bits 3:0 of the addressed input register, and takes them from `bus_d[11:8]`. Bits 11:4 are kept.
- R5: Output words change only on an edge where `wr2` is high. Input-register writes alone never reach the outputs.
- R6: On an edge where `wr2` and `xfer` are high and `clr` is low, all four outputs load from their input registers at once. Each output word is computed from its 12-bit code c in two parts. Output bits 15:9 are a thermometer in which value n = c[11:9] sets the n lowest bits. Output bits 8:0 are c[8:0].
- R7: On an edge where `wr2` and `clr` are high, every output word becomes 0x1E00, whatever `xfer` is. With `wr2` low, `clr` has no effect.
- R8: A transfer on the same edge as a write copies the input register value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_d | input | 12 | Data bus |
| addr | input | 2 | Input register select |
| wide | input | 1 | Bus-width select: high gives a full 12-bit load, low gives a low-nibble load |
| cs | input | 1 | Chip select |
| wr1 | input | 1 | First write strobe (input registers) |
| wr2 | input | 1 | Second write strobe (output registers) |
| xfer | input | 1 | Transfer request, qualified by wr2 |
| clr | input | 1 | Clear request, qualified by wr2 |
| dac_words | output | 64 | Four 16-bit segmented output words, channel 0 in bits 15:0 |

## Verification
The bench builds the block with its default parameters: a 12-bit code, a 3-bit segment field and four channels. At this size every one of the 4096 codes can be written, transferred and checked at the output. Across that sweep every channel address is used and all eight thermometer levels appear. The same size allows a sweep of the two-part narrow write over sampled upper bytes and all sixteen nibbles. Around these sweeps the bench checks the clear-over-transfer priority, the transfer on the same edge as a write, gated strobes and a reset taken in mid-run.

// File: rtl/quad_dac_front.sv
module quad_dac_front #(
  parameter int CODE_W   = 12,
  parameter int SEG_W    = 3,
  parameter int CHANNELS = 4,
  parameter int NIB_W    = 4,
  localparam int ADDR_W  = $clog2(CHANNELS),
  localparam int THERM_W = (1 << SEG_W) - 1,
  localparam int LOW_W   = CODE_W - SEG_W,
  localparam int WORD_W  = THERM_W + LOW_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CODE_W-1:0]          bus_d,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wide,
  input  logic                       cs,
  input  logic                       wr1,
  input  logic                       wr2,
  input  logic                       xfer,
  input  logic                       clr,
  output logic [CHANNELS*WORD_W-1:0] dac_words
);

  function automatic logic [WORD_W-1:0] seg_encode(input logic [CODE_W-1:0] c);
    logic [THERM_W-1:0] t;
    for (int j = 0; j < THERM_W; j++)
      t[j] = (int'(c[CODE_W-1 -: SEG_W]) > j);
    return {t, c[LOW_W-1:0]};
  endfunction

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [WORD_W-1:0] MID_WORD = seg_encode(MID_CODE);

  logic                wr_en;
  logic [CODE_W-1:0]   in_q  [CHANNELS];
  logic [WORD_W-1:0]   out_q [CHANNELS];

  assign wr_en = cs && wr1;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    logic sel;
    logic [THERM_W-1:0] therm;
    assign sel   = wr_en && (addr == ADDR_W'(g));
    assign therm = out_q[g][WORD_W-1 -: THERM_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        in_q[g] <= MID_CODE;
      else if (sel) begin
        if (wide)
          in_q[g] <= bus_d;
        else
          in_q[g][NIB_W-1:0] <= bus_d[CODE_W-1 -: NIB_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        out_q[g] <= MID_WORD;
      else if (wr2 && clr)
        out_q[g] <= MID_WORD;
      else if (wr2 && xfer)
        out_q[g] <= seg_encode(in_q[g]);
    end

    assign dac_words[g*WORD_W +: WORD_W] = out_q[g];

    assert_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(in_q[g]));
    assert_narrow_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !wide) |=> $stable(in_q[g][CODE_W-1:NIB_W]));
    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr2 |=> $stable(out_q[g]));
    assert_therm_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (therm & (therm + THERM_W'(1))) == '0);
    assert_clr_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr2 && clr) |=> out_q[g] == MID_WORD);
  end

endmodule

// File: tb/quad_dac_front_tb.sv
module quad_dac_front_tb;
  localparam int PERIOD = 10;
  localparam logic [15:0] MID = 16'h1E00;

  logic clk = 0, rst_n = 0;
  logic [11:0] bus_d = 0;
  logic [1:0] addr = 0;
  logic wide = 0, cs = 0, wr1 = 0, wr2 = 0, xfer = 0, clr = 0;
  logic [63:0] dac_words;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [11:0] m_in [4];
  logic [15:0] m_out [4];

  quad_dac_front u_dut (.clk(clk), .rst_n(rst_n), .bus_d(bus_d), .addr(addr),
    .wide(wide), .cs(cs), .wr1(wr1), .wr2(wr2), .xfer(xfer), .clr(clr),
    .dac_words(dac_words));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [15:0] enc(input logic [11:0] c);
    int n = c >> 9;
    return 16'((((1 << n) - 1) << 9) | (c & 12'h1FF));
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_in[i] = 12'h800; m_out[i] = MID; end
  endtask

  task automatic drive(input bit c, w1, w2, x, cl, wd, input logic [1:0] a, input logic [11:0] d);
    @(negedge clk);
    cs = c; wr1 = w1; wr2 = w2; xfer = x; clr = cl; wide = wd; addr = a; bus_d = d;
    @(posedge clk);
    for (int i = 0; i < 4; i++)
      if (w2 && cl) m_out[i] = MID;
      else if (w2 && x) m_out[i] = enc(m_in[i]);
    if (c && w1) begin
      if (wd) m_in[a] = d;
      else m_in[a][3:0] = d[11:8];
    end
    #1;
  endtask

  task automatic idle(); drive(0,0,0,0,0,1,0,0); endtask
  task automatic wwrite(input logic [1:0] a, input logic [11:0] d); drive(1,1,0,0,0,1,a,d); endtask
  task automatic nwrite(input logic [1:0] a, input logic [11:0] d); drive(1,1,0,0,0,0,a,d); endtask
  task automatic xfr(); drive(0,0,1,1,0,1,0,0); endtask

  task automatic check_all(input string req);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      checks++;
      if (dac_words[i*16 +: 16] !== m_out[i]) begin
        errors++;
        $display("FAIL %s ch%0d actual %h expected %h", req, i, dac_words[i*16 +: 16], m_out[i]);
      end
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    model_reset();
    #(PERIOD*3);
    check_all("R1");
    rst_n = 1;
    idle();
    check_all("R1");
    xfr();
    check_all("R1");

    for (int c = 0; c < 4096; c++) begin
      wwrite(2'(c % 4), 12'(c));
      if (c % 256 == 0) check_all("R5");
      xfr();
      check_all("R2 R6");
    end

    wwrite(0, 12'h123); wwrite(1, 12'h456); wwrite(2, 12'h789); wwrite(3, 12'hABC);
    xfr(); check_all("R2");
    drive(0,1,0,0,0,1,0,12'hFFF);
    drive(1,0,0,0,0,1,1,12'h000);
    drive(1,0,0,0,0,0,2,12'h555);
    drive(0,1,0,0,0,0,3,12'hAAA);
    xfr(); check_all("R3");

    for (int hb = 0; hb < 256; hb += 17) begin
      for (int nb = 0; nb < 16; nb++) begin
        logic [1:0] a = 2'((hb + nb) % 4);
        wwrite(a, 12'((hb << 4) | ((nb * 5) & 15)));
        nwrite(a, 12'((nb << 8) | ((hb * 3) & 8'hFF)));
        check_all("R5");
        xfr();
        check_all("R4");
      end
    end

    drive(0,0,0,0,1,1,0,0); check_all("R7");
    drive(0,0,0,1,0,1,0,0); check_all("R5");
    drive(0,0,1,0,1,1,0,0); check_all("R7");
    wwrite(1, 12'hFFF); wwrite(2, 12'h000); xfr(); check_all("R6");
    wwrite(1, 12'h3C5);
    drive(0,0,1,1,1,1,0,0); check_all("R7");

    wwrite(3, 12'h111); xfr(); check_all("R6");
    drive(1,1,1,1,0,1,3,12'hEEE); check_all("R8");
    xfr(); check_all("R8");

    wwrite(0, 12'h9A7); xfr(); check_all("R6");
    @(negedge clk); rst_n = 0; model_reset();
    #2; check_all("R1");
    rst_n = 1;
    xfr(); check_all("R1");

    finish_up();
  end
endmodule